// File: doc/BRIEF.md
# Active Priority and Running Priority Tracker

This block records which priority levels of virtual interrupts are currently being serviced. It holds one bitmap for group 0 and one for group 1. When an interrupt is activated, the bit for its priority is set in its group's bitmap. When an interrupt ends, a bit is cleared again. From the two bitmaps it derives the running priority: the most urgent level that is still active. It also produces the value that a running-priority read returns.

A non-maskable activation does not use a priority bit. It sets a single dedicated flag that belongs to word 0 of the group 1 bitmap. While that flag is set, the running priority is forced to zero and the read value carries a flag bit. Direct writes can load the bitmaps, for example when an interrupt context is restored. Each accepted activation sends a one-cycle pulse back to the list entry, telling it to drop its pending state and become active.

The parameter `PREEMPT_BITS` sets how many preemption levels exist; the bitmap holds 2^PREEMPT_BITS bits. The parameter `NMI_SUPPORT` decides whether the non-maskable flag exists at all.

Top module: `apt_tracker`

## Requirements
- R1: On a non-NMI activation, the priority is ANDed with `act_gmask` and shifted right by (8 - PREEMPT_BITS) to give an index. Bit (index mod 32) of word (index / 32) is then set in the bitmap of `act_group`.
- R2: With NMI_SUPPORT=1, an activation with `act_nmi`=1 sets only the NMI flag, whatever `act_group` is. The NMI flag reads back as `rd_data[32]` of group 1 word 0. No priority bit is set.
- R3: `lr_upd` is high for exactly the one cycle that follows each accepted activation, and low otherwise.
- R4: While the NMI flag is set: `run_prio` is 8'h00, `nmi_active` is 1, and `rpr_rd` is {1'b1, 8'h00}.
- R5: While the NMI flag is clear, take the lowest set bit index of (group 0 OR group 1). `run_prio` is that index shifted left by (8 - PREEMPT_BITS). If no bit is set, `run_prio` is 8'hFF. `rpr_rd[8]` is 0.
- R6: A direct write replaces word `wr_word` of group `wr_group`, keeping only the valid priority bits. `wr_data[32]` loads the NMI flag only when NMI_SUPPORT=1, the group is 1 and the word is 0. A write to a word index beyond the bitmap has no effect.
- R7: With NMI_SUPPORT=0, `act_nmi` is ignored and the activation sets its priority bit as in R1. `nmi_active` and `rd_data[32]` stay 0.
- R8: On end-of-interrupt with `eoi_group`=1 while the NMI flag is set, only the NMI flag is cleared. Otherwise, the lowest set bit of (group 0 OR group 1) is cleared in the bitmap of `eoi_group`.
- R9: When strobes coincide in one cycle, only one takes effect. A direct write takes precedence over an activation, and an activation over an end-of-interrupt.
- R10: After reset, both bitmaps and the NMI flag are clear, `run_prio` is 8'hFF and `lr_upd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| act_valid | input | 1 | Activation strobe |
| act_prio | input | 8 | Priority of the activated entry |
| act_gmask | input | 8 | Group-priority mask applied to act_prio |
| act_group | input | 1 | Group of the activated entry |
| act_nmi | input | 1 | Non-maskable flag of the activated entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_group | input | 1 | Group of the ending interrupt |
| wr_valid | input | 1 | Direct bitmap write strobe |
| wr_group | input | 1 | Group being written |
| wr_word | input | WSEL_W | Word index being written |
| wr_data | input | 33 | Write data; bit 32 is the NMI flag |
| rd_group | input | 1 | Group being read |
| rd_word | input | WSEL_W | Word index being read |
| rd_data | output | 33 | Bitmap word; bit 32 is the NMI flag (group 1 word 0 only) |
| run_prio | output | 8 | Running priority |
| nmi_active | output | 1 | NMI flag is set |
| rpr_rd | output | 9 | Running-priority read value, bit 8 the NMI flag |
| lr_upd | output | 1 | Clear-pending/set-active pulse to the list entry |

## Verification
A strobe that is present at a rising edge changes the bitmaps at that same edge. `run_prio`, `nmi_active`, `rpr_rd` and `rd_data` are combinational from the stored state, so they show the new state during the cycle that follows. `lr_upd` is registered and also appears in that following cycle. The bench drives each stimulus on a falling edge and removes it at the next falling edge, and compares every output there, exactly one rising edge later. Because of the two-stage reset synchroniser, the bench waits several cycles after reset is released before it takes the reset-state check.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int WORD_W       = 32;
  localparam int NMI_RD_POS   = 32;
  localparam int RPR_NMI_POS  = 8;
  localparam logic [7:0] PRIO_IDLE = 8'hFF;

  function automatic int map_bits(input int pb);
    return 1 << pb;
  endfunction

  function automatic int word_bits(input int pb);
    return (map_bits(pb) < WORD_W) ? map_bits(pb) : WORD_W;
  endfunction

  function automatic int map_words(input int pb);
    return map_bits(pb) / word_bits(pb);
  endfunction
endpackage

// File: rtl/apt_lowest.sv
module apt_lowest #(
  parameter int NBITS = 32,
  parameter int IDXW  = 5
) (
  input  logic [NBITS-1:0] vec,
  output logic             found,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/apt_bank.sv
module apt_bank #(
  parameter int NBITS  = 32,
  parameter int WBITS  = 32,
  parameter int NWORDS = 1,
  parameter int IDXW   = 5,
  parameter int WSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IDXW-1:0]   set_idx,
  input  logic              clr_en,
  input  logic [IDXW-1:0]   clr_idx,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  output logic [NBITS-1:0]  bits_o
);
  logic [NBITS-1:0] bits_q, bits_d;
  logic             upd_en;

  assign upd_en = wr_en | set_en | clr_en;

  always_comb begin
    bits_d = bits_q;
    if (wr_en) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (wr_word == WSEL_W'(w)) bits_d[w*WBITS +: WBITS] = wr_data[WBITS-1:0];
      end
    end else if (set_en) begin
      bits_d[set_idx] = 1'b1;
    end else if (clr_en) begin
      bits_d[clr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (upd_en) bits_q <= bits_d;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (rd_word == WSEL_W'(w)) rd_data[WBITS-1:0] = bits_q[w*WBITS +: WBITS];
    end
  end

  assign bits_o = bits_q;

  assert_set_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !wr_en) |=> bits_q[$past(set_idx)]);

  assert_clr_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en && !set_en) |=> !bits_q[$past(clr_idx)]);
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
  import apt_pkg::*;
#(
  parameter int PREEMPT_BITS = 5,
  parameter bit NMI_SUPPORT  = 1'b1,
  localparam int NWORDS = map_words(PREEMPT_BITS),
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [7:0]        act_prio,
  input  logic [7:0]        act_gmask,
  input  logic              act_group,
  input  logic              act_nmi,
  input  logic              eoi_valid,
  input  logic              eoi_group,
  input  logic              wr_valid,
  input  logic              wr_group,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [32:0]       wr_data,
  input  logic              rd_group,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [32:0]       rd_data,
  output logic [7:0]        run_prio,
  output logic              nmi_active,
  output logic [8:0]        rpr_rd,
  output logic              lr_upd
);
  localparam int NBITS = map_bits(PREEMPT_BITS);
  localparam int WBITS = word_bits(PREEMPT_BITS);
  localparam int IDXW  = PREEMPT_BITS;
  localparam int SHIFT = 8 - PREEMPT_BITS;

  // reset synchroniser: asserts at once, releases after two edges
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // one strobe per cycle: write, then activate, then end-of-interrupt
  logic act_go, eoi_go, nmi_req, eoi_nmi;
  logic [7:0] act_masked;
  logic [IDXW-1:0] act_idx;
  assign act_go     = act_valid & ~wr_valid;
  assign eoi_go     = eoi_valid & ~wr_valid & ~act_valid;
  assign nmi_req    = act_nmi & NMI_SUPPORT;
  assign act_masked = act_prio & act_gmask;
  assign act_idx    = IDXW'(act_masked >> SHIFT);

  logic [NBITS-1:0] bits_g [2];
  logic [31:0]      rdw_g  [2];
  logic [NBITS-1:0] comb_map;
  logic             low_found;
  logic [IDXW-1:0]  low_idx;
  logic             nmi_q;

  assign comb_map = bits_g[0] | bits_g[1];
  assign eoi_nmi  = eoi_go & eoi_group & nmi_q;

  apt_lowest #(.NBITS(NBITS), .IDXW(IDXW)) u_lowest (
    .vec(comb_map), .found(low_found), .idx(low_idx)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    apt_bank #(.NBITS(NBITS), .WBITS(WBITS), .NWORDS(NWORDS), .IDXW(IDXW),
               .WSEL_W(WSEL_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_s),
      .set_en  (act_go & ~nmi_req & (act_group == 1'(g))),
      .set_idx (act_idx),
      .clr_en  (eoi_go & ~eoi_nmi & low_found & (eoi_group == 1'(g))),
      .clr_idx (low_idx),
      .wr_en   (wr_valid & (wr_group == 1'(g))),
      .wr_word (wr_word),
      .wr_data (wr_data[31:0]),
      .rd_word (rd_word),
      .rd_data (rdw_g[g]),
      .bits_o  (bits_g[g])
    );
  end

  if (NMI_SUPPORT) begin : g_nmi
    logic nmi_d, nmi_en, nmi_wr;
    assign nmi_wr = wr_valid & wr_group & (wr_word == '0);
    assign nmi_en = nmi_wr | (act_go & nmi_req) | eoi_nmi;
    always_comb begin
      nmi_d = nmi_q;
      if (nmi_wr)                nmi_d = wr_data[NMI_RD_POS];
      else if (act_go & nmi_req) nmi_d = 1'b1;
      else if (eoi_nmi)          nmi_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s)      nmi_q <= 1'b0;
      else if (nmi_en) nmi_q <= nmi_d;
    end
  end else begin : g_no_nmi
    assign nmi_q = 1'b0;
  end

  logic [7:0] idx8;
  assign idx8 = 8'(low_idx);

  always_comb begin
    if (nmi_q)          run_prio = 8'h00;
    else if (low_found) run_prio = idx8 << SHIFT;
    else                run_prio = PRIO_IDLE;
  end

  assign nmi_active = nmi_q;
  assign rpr_rd     = {nmi_q, run_prio};
  assign rd_data    = {rd_group & (rd_word == '0) & nmi_q, rdw_g[rd_group]};

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) lr_upd <= 1'b0;
    else        lr_upd <= act_go;
  end

  assert_upd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_s)
    act_go |=> lr_upd);

  assert_upd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (!act_valid || wr_valid) |=> !lr_upd);

  assert_nmi_set_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (act_go && nmi_req) |=> (nmi_active && $stable(comb_map)));

  assert_eoi_nmi_first_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (eoi_go && eoi_group && nmi_active) |=> (!nmi_active && $stable(comb_map)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_valid && !wr_group && act_valid && act_group) |=> $stable(bits_g[1]));
endmodule

// File: tb/test_apt_tracker.sv
module test_apt_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic act_valid = 0, act_group = 0, act_nmi = 0;
  logic [7:0] act_prio = 0, act_gmask = 8'hFF;
  logic eoi_valid = 0, eoi_group = 0;
  logic wr_valid = 0, wr_group = 0;
  logic [0:0] wr_word = 0, rd_word = 0;
  logic [32:0] wr_data = 0;
  logic rd_group = 0;

  logic [32:0] rd_data, s_rd_data;
  logic [7:0]  run_prio, s_run_prio;
  logic        nmi_active, s_nmi_active, lr_upd, s_lr_upd;
  logic [8:0]  rpr_rd, s_rpr_rd;

  apt_tracker #(.PREEMPT_BITS(5), .NMI_SUPPORT(1'b1)) i_apt_tracker (
    .clk, .rst_n, .act_valid, .act_prio, .act_gmask, .act_group, .act_nmi,
    .eoi_valid, .eoi_group, .wr_valid, .wr_group, .wr_word, .wr_data,
    .rd_group, .rd_word, .rd_data, .run_prio, .nmi_active, .rpr_rd, .lr_upd);

  apt_tracker #(.PREEMPT_BITS(3), .NMI_SUPPORT(1'b0)) i_small (
    .clk, .rst_n, .act_valid, .act_prio, .act_gmask, .act_group, .act_nmi,
    .eoi_valid, .eoi_group, .wr_valid, .wr_group, .wr_word, .wr_data,
    .rd_group, .rd_word, .rd_data(s_rd_data), .run_prio(s_run_prio),
    .nmi_active(s_nmi_active), .rpr_rd(s_rpr_rd), .lr_upd(s_lr_upd));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state of the main instance
  logic [31:0] m0 = 0, m1 = 0;
  logic mn = 0, m_upd = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check_main(input string tag);
    int l;
    logic [7:0] er;
    l = lowest(m0 | m1);
    er = mn ? 8'h00 : (l < 0 ? 8'hFF : 8'(l << 3));
    chk({tag, " R4/R5 run_prio"}, 64'(run_prio), 64'(er));
    chk({tag, " R4 nmi_active"}, 64'(nmi_active), 64'(mn));
    chk({tag, " R4/R5 rpr_rd"}, 64'(rpr_rd), 64'({mn, er}));
    chk({tag, " R3 lr_upd"}, 64'(lr_upd), 64'(m_upd));
    rd_word = 0;
    rd_group = 0; #1;
    chk({tag, " R1/R6 rd g0"}, 64'(rd_data), 64'({1'b0, m0}));
    rd_group = 1; #1;
    chk({tag, " R1/R2 rd g1"}, 64'(rd_data), 64'({mn, m1}));
  endtask

  // one cycle of stimulus, reference update, check one edge later
  task automatic op(input string tag,
                    input logic wv, input logic wg, input logic ww, input logic [32:0] wd,
                    input logic av, input logic [7:0] ap, input logic [7:0] am,
                    input logic ag, input logic an, input logic ev, input logic eg);
    int l;
    int idx;
    wr_valid = wv; wr_group = wg; wr_word = ww; wr_data = wd;
    act_valid = av; act_prio = ap; act_gmask = am; act_group = ag; act_nmi = an;
    eoi_valid = ev; eoi_group = eg;
    if (wv) begin
      if (ww == 0) begin
        if (wg) begin m1 = wd[31:0]; mn = wd[32]; end
        else m0 = wd[31:0];
      end
    end else if (av) begin
      if (an) mn = 1;
      else begin
        idx = int'((ap & am) >> 3);
        if (ag) m1[idx] = 1'b1; else m0[idx] = 1'b1;
      end
    end else if (ev) begin
      if (eg && mn) mn = 0;
      else begin
        l = lowest(m0 | m1);
        if (l >= 0) begin
          if (eg) m1[l] = 1'b0; else m0[l] = 1'b0;
        end
      end
    end
    m_upd = av & ~wv;
    @(negedge clk);
    wr_valid = 0; act_valid = 0; eoi_valid = 0;
    check_main(tag);
  endtask

  task automatic act(input string tag, input logic [7:0] p, input logic [7:0] m,
                     input logic g, input logic n);
    op(tag, 0, 0, 0, 33'h0, 1, p, m, g, n, 0, 0);
  endtask

  task automatic eoi(input string tag, input logic g);
    op(tag, 0, 0, 0, 33'h0, 0, 8'h0, 8'hFF, 0, 0, 1, g);
  endtask

  task automatic wr(input string tag, input logic g, input logic w, input logic [32:0] d);
    op(tag, 1, g, w, d, 0, 8'h0, 8'hFF, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    m_upd = 0;
    check_main("R10 reset");
    chk("R10 small run_prio", 64'(s_run_prio), 64'hFF);

    // R1 R5 R8: sweep every priority in both groups, full and coarse masks
    for (int p = 0; p < 256; p++) begin
      act("R1 sweep", 8'(p), 8'hFF, p[0], 1'b0);
      eoi("R8 sweep", p[0]);
    end
    for (int p = 0; p < 256; p += 7) begin
      act("R1 masked", 8'(p), 8'hC0, p[1], 1'b0);
      eoi("R8 masked", p[1]);
    end

    // R5 R8: several levels in both groups, retire in order
    act("R5 multi", 8'h90, 8'hFF, 0, 0);
    act("R5 multi", 8'h28, 8'hFF, 1, 0);
    act("R5 multi", 8'hF8, 8'hFF, 1, 0);
    act("R5 multi", 8'h2F, 8'hFF, 0, 0);
    eoi("R8 wrong group", 1);
    eoi("R8 ordered", 0);
    eoi("R8 ordered", 0);
    eoi("R8 ordered", 1);
    eoi("R8 empty", 0);

    // R2 R4 R8: non-maskable activation and its retirement order
    act("R5 pre-nmi", 8'h40, 8'hFF, 1, 0);
    act("R2 nmi", 8'hC8, 8'hFF, 1, 1);
    act("R2 nmi grp0", 8'h10, 8'hFF, 0, 1);
    eoi("R8 grp0 under nmi", 0);
    eoi("R8 nmi first", 1);
    eoi("R8 after nmi", 1);

    // R6: direct writes
    wr("R6 g0 nmi ignored", 0, 0, 33'h1_8000_0100);
    wr("R6 g1 nmi load", 1, 0, 33'h1_0000_0004);
    wr("R6 bad word", 1, 1, 33'h0_0000_0001);
    wr("R6 g1 clear", 1, 0, 33'h0);

    // R9: coincident strobes
    op("R9 wr over act", 1, 0, 0, 33'h0_0000_0000, 1, 8'h08, 8'hFF, 1, 0, 0, 0);
    op("R9 act over eoi", 0, 0, 0, 33'h0, 1, 8'h18, 8'hFF, 0, 0, 1, 0);
    op("R9 wr over eoi", 1, 1, 0, 33'h0_0000_0002, 0, 8'h0, 8'hFF, 0, 0, 1, 1);

    // R7 R6 on the instance without NMI support, three preemption bits
    wr("R7 prep", 0, 0, 33'h0);
    wr("R7 prep", 1, 0, 33'h0);
    act("R7 main", 8'h47, 8'hFF, 0, 1);
    chk("R7 small run_prio", 64'(s_run_prio), 64'h40);
    chk("R7 small nmi_active", 64'(s_nmi_active), 64'h0);
    chk("R3 small lr_upd", 64'(s_lr_upd), 64'h1);
    rd_group = 0; rd_word = 0; #1;
    chk("R7 small rd g0", 64'(s_rd_data), 64'h4);
    wr("R6 main", 1, 0, 33'h1_FFFF_FFFF);
    rd_group = 1; rd_word = 0; #1;
    chk("R6 small rd g1", 64'(s_rd_data), 64'hFF);
    chk("R6 small rpr_rd", 64'(s_rpr_rd), 64'h000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule